// File: doc/BRIEF.md
# Programmable Rate Divider

This block turns a free-running clock into a periodic one-cycle enable whose spacing is set at run time. An 8-bit divisor input picks the number of clock cycles between enables. Inside, a down counter is preloaded from the divisor, steps down by one on each clock, and reloads on the edge after it reaches zero. The same edge raises the enable for one cycle. Logic downstream runs on the main clock and uses the enable to do its work at the divided rate, so no second clock domain is created.

The reload is synchronous. The zero state lasts a full clock period and is one of the N states in a period, which makes the ratio exact for any divisor from 2 to 255. A divisor of 0 or 1 keeps the counter at zero, so the enable is high on every cycle. A new divisor written partway through a period does not shorten or stretch that period. It is first used at the next reload.

Top module: `rate_divider`

## Requirements
- R1: While the asynchronous reset `rst_n` is low, `count` is 0, `tick` is 0 and `at_min` is 1.
- R2: On a clock edge where `count` is not zero, `count` decreases by exactly one.
- R3: On a clock edge where `count` is zero, `count` is loaded with `divisor - 1`, or with 0 if `divisor` is 0 or 1. The `divisor` value used is the one present at that edge.
- R4: `tick` is high for exactly the cycle that follows a reload edge, and low in every other cycle.
- R5: With a steady divisor N from 2 to 255, rising `tick` cycles are exactly N clock cycles apart. This holds for 15, 100 and 255.
- R6: With a divisor of 0 or 1, `tick` is high on every cycle after reset and `count` stays at 0.
- R7: A divisor change in the middle of a period leaves that period at its old length. The next period has the new length.
- R8: `at_min` is 1 exactly when `count` is 0.
- R9: After the reset is released, the first clock edge performs a load, so `tick` is high in the first cycle. A reset applied in the middle of a count clears the count at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| divisor | input | 8 | Division ratio, sampled at each reload edge |
| tick | output | 1 | One-cycle enable, once per period |
| count | output | 8 | Current down-counter value |
| at_min | output | 1 | High while the counter is at zero |

## Verification
The assertions take two things as given. First, `divisor` has a known value at every clock edge where the counter sits at zero. Second, `rst_n` is only released away from a clock edge. The stimulus changes `divisor` and `rst_n` one nanosecond after a falling edge, so both are stable at every rising edge. Mid-period divisor changes are also driven at that point, so they fall well away from the reload edge under test. Outputs are compared on every falling edge against a behavioural model, and tick spacing is measured separately for each divisor.

// File: rtl/div_pkg.sv
package div_pkg;

    // Default counter width and the action the counter takes on the next edge.
    localparam int DIV_W_DEFAULT = 8;

    typedef enum logic {
        OP_DEC  = 1'b0,
        OP_LOAD = 1'b1
    } div_op_e;

endpackage

// File: rtl/div_reload_calc.sv
module div_reload_calc #(
    parameter int W = 8
) (
    input  logic [W-1:0] factor,
    output logic [W-1:0] reload_val
);
    localparam logic [W-1:0] ONE = W'(1);

    // The zero state is one of the N states, so load N-1; factors 0 and 1 pin the count at zero.
    always_comb begin
        if (factor > ONE) reload_val = factor - ONE;
        else              reload_val = '0;
    end
endmodule

// File: rtl/div_zero_detect.sv
module div_zero_detect #(
    parameter int W = 8
) (
    input  logic [W-1:0] cnt,
    output logic         is_zero
);
    assign is_zero = ~|cnt;
endmodule

// File: rtl/div_down_counter.sv
module div_down_counter
    import div_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  div_op_e      op,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] cnt_q,
    output logic         tick_q
);
    typedef struct packed {
        logic [W-1:0] cnt;
        logic         tick;
    } ctr_st_t;

    ctr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (op)
            OP_LOAD: begin
                st_d.cnt  = load_val;
                st_d.tick = 1'b1;
            end
            default: begin
                st_d.cnt  = st_q.cnt - W'(1);
                st_d.tick = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_q  = st_q.cnt;
    assign tick_q = st_q.tick;
endmodule

// File: rtl/rate_divider.sv
module rate_divider
    import div_pkg::*;
#(
    parameter int W = DIV_W_DEFAULT
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] divisor,
    output logic         tick,
    output logic [W-1:0] count,
    output logic         at_min
);
    logic [W-1:0] reload_val;
    logic         is_zero;
    div_op_e      op;

    div_reload_calc #(.W(W)) u_reload (
        .factor     (divisor),
        .reload_val (reload_val)
    );

    div_zero_detect #(.W(W)) u_zero (
        .cnt     (count),
        .is_zero (is_zero)
    );

    // Reaching zero selects a synchronous reload on the next edge.
    always_comb op = is_zero ? OP_LOAD : OP_DEC;

    div_down_counter #(.W(W)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .op       (op),
        .load_val (reload_val),
        .cnt_q    (count),
        .tick_q   (tick)
    );

    assign at_min = is_zero;
endmodule

// File: rtl/rate_divider_chk.sv
module rate_divider_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] divisor,
    input logic         tick,
    input logic [W-1:0] count,
    input logic         at_min
);
    // R2: step down by one away from zero
    a_r2_step_down: assert property (@(posedge clk) disable iff (!rst_n)
        !at_min |=> (count == $past(count) - W'(1)));

    // R3: reload from the divisor sampled at the zero edge
    a_r3_reload: assert property (@(posedge clk) disable iff (!rst_n)
        at_min |=> (($past(divisor) > W'(1)) ? (count == $past(divisor) - W'(1))
                                             : (count == '0)));

    // R4: enable follows a reload edge
    a_r4_tick_on_load: assert property (@(posedge clk) disable iff (!rst_n)
        at_min |=> tick);

    // R4: no enable after a plain decrement
    a_r4_tick_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !at_min |=> !tick);

    // R5: a loaded value never exceeds the largest divisor minus one
    a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count != '1);

    // R8: flag tracks a zero count
    a_r8_min_flag: assert property (@(posedge clk) disable iff (!rst_n)
        at_min == (count == '0));
endmodule

bind rate_divider rate_divider_chk #(.W(W)) i_rate_divider_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .divisor (divisor),
    .tick    (tick),
    .count   (count),
    .at_min  (at_min)
);

// File: tb/test_rate_divider.sv
module test_rate_divider;
    logic       clk = 1'b0;
    logic       rst_n = 1'b1;
    logic [7:0] divisor = 8'd15;
    logic       tick;
    logic [7:0] count;
    logic       at_min;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    rate_divider i_rate_divider (
        .clk     (clk),
        .rst_n   (rst_n),
        .divisor (divisor),
        .tick    (tick),
        .count   (count),
        .at_min  (at_min)
    );

    always #4 clk = ~clk;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Behavioural reference model
    int m_cnt = 0;
    bit m_tick = 1'b0;
    bit m_prev_zero = 1'b1;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt = 0; m_tick = 1'b0; m_prev_zero = 1'b1;
        end else begin
            m_prev_zero = (m_cnt == 0);
            if (m_cnt == 0) begin
                m_cnt  = (int'(divisor) <= 1) ? 0 : int'(divisor) - 1;
                m_tick = 1'b1;
            end else begin
                m_cnt  = m_cnt - 1;
                m_tick = 1'b0;
            end
        end
    end

    // Compare every cycle
    always @(negedge clk) begin
        if (!done) begin
            check(int'(count) == m_cnt, m_prev_zero ? "R3 count" : "R2 count", int'(count), m_cnt);
            check(tick == m_tick, "R4 tick", int'(tick), int'(m_tick));
            check(at_min == (m_cnt == 0), "R8 at_min", int'(at_min), int'(m_cnt == 0));
        end
    end

    task automatic wait_tick();
        do @(negedge clk); while (!tick);
    endtask

    task automatic measure(input int n, input int reps, input string tag);
        int exp = (n <= 1) ? 1 : n;
        for (int r = 0; r < reps; r++) begin
            int gap = 0;
            do begin @(negedge clk); gap++; end while (!tick);
            check(gap == exp, tag, gap, exp);
        end
    endtask

    task automatic set_div(input int n);
        @(negedge clk); #1;
        divisor = 8'(n);
    endtask

    initial begin
        #1 rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(count == 8'd0, "R1 count in reset", int'(count), 0);
        check(tick == 1'b0, "R1 tick in reset", int'(tick), 0);
        check(at_min == 1'b1, "R1 at_min in reset", int'(at_min), 1);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(tick == 1'b1, "R9 first edge loads (tick)", int'(tick), 1);
        check(int'(count) == 14, "R9 first edge loads (count)", int'(count), 14);

        // R5: exact periods
        wait_tick(); measure(15, 3, "R5 period 15");
        set_div(100); wait_tick(); measure(100, 3, "R5 period 100");
        set_div(255); wait_tick(); measure(255, 2, "R5 period 255");
        set_div(2); wait_tick(); measure(2, 4, "R5 period 2");

        // R6: pass-through factors
        set_div(1); wait_tick(); wait_tick(); measure(1, 5, "R6 factor 1");
        check(count == 8'd0, "R6 count pinned", int'(count), 0);
        set_div(0); wait_tick(); wait_tick(); measure(0, 5, "R6 factor 0");
        check(at_min == 1'b1, "R6 at_min held", int'(at_min), 1);

        // R7: mid-period change waits for next reload
        set_div(100); wait_tick(); wait_tick();
        repeat (10) @(negedge clk);
        #1 divisor = 8'd20;
        begin
            int gap = 10;
            do begin @(negedge clk); gap++; end while (!tick);
            check(gap == 100, "R7 old period kept", gap, 100);
        end
        measure(20, 2, "R7 new period used");

        // R9: asynchronous reset mid-count
        set_div(50); wait_tick(); wait_tick();
        repeat (5) @(negedge clk);
        #1 rst_n = 1'b0;
        #1;
        check(count == 8'd0, "R9 async clear count", int'(count), 0);
        check(tick == 1'b0, "R9 async clear tick", int'(tick), 0);
        @(negedge clk); #1 rst_n = 1'b1;
        @(negedge clk);
        check(tick == 1'b1, "R9 load after release (tick)", int'(tick), 1);
        check(int'(count) == 49, "R9 load after release (count)", int'(count), 49);
        measure(50, 2, "R5 period 50 after reset");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            done = 1'b1;
            tests++; fails++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule